// File: doc/BRIEF.md
# Speculative Load Order Guard

This block watches over loads that were allowed to execute ahead of older stores whose addresses were not yet known. Each load takes a slot in program order when it is dispatched. When it executes, the slot records the byte range it read. Slots are released in order as loads retire. Two events can prove such a load wrong. The first is an older store that later resolves to an address overlapping the load's bytes. The second is a coherence invalidation from another core that hits a cache line the load read before it retired. In either case the block raises a squash request carrying the sequence tag of the oldest offending load, so the pipeline can discard that load and its consumers and replay them.

Sequence tags carry a wrap bit in their top position, so older and younger can be told apart across tag wraparound. A misprediction flush removes every slot younger than a given tag and raises no squash. Loads to memory-mapped I/O space never execute speculatively, so their slots are never checked. Flushing the pipeline and replaying the loads are handled elsewhere.

Top module: `spec_load_guard`

## Requirements
- R1: After reset the guard holds no loads, `alloc_ready` is 1 and `squash_valid` is 0.
- R2: An allocation takes the next slot in program order. `alloc_ready` is 0 exactly when DEPTH loads are held. An allocation offered while `alloc_ready` is 0 has no effect.
- R3: An execute event marks the held, non-I/O load whose tag equals `exec_tag` as executed. It records the byte range `exec_addr` through `exec_addr + exec_len` inclusive, because `exec_len` holds the byte count minus one.
- R4: A store-resolve event flags every executed load that is strictly younger than `st_tag` and whose byte range shares at least one byte with `st_addr` through `st_addr + st_len`. A load with a tag equal to or older than the store, or ranges that only touch end to end, is not flagged.
- R5: Tag A is older than tag B when their top (wrap) bits are equal and the lower bits of A are smaller, or when their top bits differ and the lower bits of A are larger.
- R6: An invalidation event carries a byte address whose line is the address shifted right by LINE_SH. It flags every executed, unretired load whose byte range touches that line.
- R7: When several loads are flagged in one cycle, by a store, an invalidation or both, the reported tag is that of the oldest flagged load.
- R8: A slot allocated with `alloc_mmio` set is never marked executed and is never flagged.
- R9: A retire event frees the oldest held load. It is ignored when the guard is empty or when `flush_valid` is 1 in the same cycle.
- R10: A flush removes every held load strictly younger than `flush_tag` and raises no squash. Hits on loads removed in that cycle are dropped, and an allocation offered in a flush cycle is ignored.
- R11: The squash request is registered. `squash_valid` is 1 for exactly the one cycle after the cycle in which loads were flagged, and `squash_tag` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a slot for a new load |
| alloc_tag | input | SEQ_W | Sequence tag of the new load |
| alloc_mmio | input | 1 | New load targets I/O space |
| alloc_ready | output | 1 | A free slot exists |
| exec_valid | input | 1 | A held load has executed |
| exec_tag | input | SEQ_W | Tag of the executed load |
| exec_addr | input | ADDR_W | First physical byte read |
| exec_len | input | LEN_W | Bytes read minus one |
| st_valid | input | 1 | An older store resolved its address |
| st_tag | input | SEQ_W | Tag of the store |
| st_addr | input | ADDR_W | First byte written by the store |
| st_len | input | LEN_W | Bytes written minus one |
| inv_valid | input | 1 | Remote invalidation arrived |
| inv_addr | input | ADDR_W | Byte address inside the invalidated line |
| ret_valid | input | 1 | Oldest held load retires |
| flush_valid | input | 1 | Misprediction flush |
| flush_tag | input | SEQ_W | Loads younger than this tag are removed |
| squash_valid | output | 1 | Ordering violation found |
| squash_tag | output | SEQ_W | Tag of the oldest offending load |

## Verification
The bench builds the guard with DEPTH=4, SEQ_W=4, ADDR_W=16, LEN_W=3 and LINE_SH=4. Four slots let a few allocations reach the full condition and the refused-allocation case. A four-bit tag wraps after eight values, so stores and loads that straddle the wrap bit are easy to set up. Sixteen-byte lines let one invalidation catch two loads at once, which exercises the oldest-first choice. Directed steps then combine a flush with a store hit, a flush with an allocation, retires on an empty guard, and a store and an invalidation in the same cycle.

// File: rtl/slg_pkg.sv
// Package: shared age and range helpers for the speculative load order guard.
// Assumes tags and addresses fit in 32 bits and that callers zero-extend them.
package slg_pkg;

    // True when tag a is older than tag b. Bit w-1 is the wrap bit.
    function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b,
                                       input int unsigned w);
        logic [31:0] mask;
        logic        same_lap;
        mask     = (32'd1 << (w - 1)) - 32'd1;
        same_lap = (((a ^ b) >> (w - 1)) & 32'd1) == 32'd0;
        if (same_lap) return (a & mask) < (b & mask);
        return (a & mask) > (b & mask);
    endfunction

    // True when the inclusive ranges [a_lo,a_hi] and [b_lo,b_hi] share a point.
    function automatic logic span_overlap(input logic [31:0] a_lo, input logic [31:0] a_hi,
                                          input logic [31:0] b_lo, input logic [31:0] b_hi);
        return (a_lo <= b_hi) && (b_lo <= a_hi);
    endfunction

endpackage

// File: rtl/slg_entry.sv
// Module: one tracked load slot.
// Holds the tag, I/O flag, executed flag and byte range of one load, and
// compares them against a resolving store and a remote invalidation.
// Assumes allocation and free never target this slot in the same cycle.
module slg_entry #(
    parameter int SEQ_W   = 6,
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 3,
    parameter int LINE_SH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [SEQ_W-1:0]  alloc_tag,
    input  logic              alloc_mmio,
    input  logic              free_en,
    input  logic              exec_valid,
    input  logic [SEQ_W-1:0]  exec_tag,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [LEN_W-1:0]  exec_len,
    input  logic              st_valid,
    input  logic [SEQ_W-1:0]  st_tag,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [LEN_W-1:0]  st_len,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              e_valid,
    output logic [SEQ_W-1:0]  e_tag,
    output logic              st_hit,
    output logic              inv_hit
);
    import slg_pkg::*;

    logic              valid_q;
    logic              done_q;
    logic              mmio_q;
    logic [SEQ_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;

    logic [31:0] ld_lo, ld_hi, sr_lo, sr_hi, inv_line;

    // Slot state: allocate, free, or capture the executed range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            mmio_q  <= 1'b0;
            tag_q   <= '0;
            addr_q  <= '0;
            len_q   <= '0;
        end else if (alloc_en) begin
            valid_q <= 1'b1;
            done_q  <= 1'b0;
            mmio_q  <= alloc_mmio;
            tag_q   <= alloc_tag;
        end else if (free_en) begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else if (exec_valid && valid_q && !mmio_q && (exec_tag == tag_q)) begin
            done_q  <= 1'b1;
            addr_q  <= exec_addr;
            len_q   <= exec_len;
        end
    end

    // Range arithmetic on 32 bits so the upper end never wraps.
    always_comb begin
        ld_lo    = 32'(addr_q);
        ld_hi    = 32'(addr_q) + 32'(len_q);
        sr_lo    = 32'(st_addr);
        sr_hi    = 32'(st_addr) + 32'(st_len);
        inv_line = 32'(inv_addr) >> LINE_SH;
    end

    // Violation tests for the store and the invalidation.
    always_comb begin
        st_hit  = st_valid && valid_q && done_q &&
                  seq_older(32'(st_tag), 32'(tag_q), SEQ_W) &&
                  span_overlap(ld_lo, ld_hi, sr_lo, sr_hi);
        inv_hit = inv_valid && valid_q && done_q &&
                  ((ld_lo >> LINE_SH) <= inv_line) && (inv_line <= (ld_hi >> LINE_SH));
    end

    assign e_valid = valid_q;
    assign e_tag   = tag_q;

endmodule

// File: rtl/slg_oldest_pick.sv
// Module: picks the oldest flagged slot.
// Slots hold loads in program order starting at the head pointer, so the
// first flagged slot found walking forward from the head is the oldest.
// Assumes DEPTH is a power of two.
module slg_oldest_pick #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 6,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            hit,
    input  logic [DEPTH-1:0][SEQ_W-1:0] tags,
    input  logic [IDX_W-1:0]            head,
    output logic                        found,
    output logic [SEQ_W-1:0]            oldest_tag
);
    logic [IDX_W-1:0] slot;

    // Forward scan from the head; the first hit wins.
    always_comb begin
        found      = 1'b0;
        oldest_tag = '0;
        slot       = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = head + IDX_W'(k);
            if (!found && hit[slot]) begin
                found      = 1'b1;
                oldest_tag = tags[slot];
            end
        end
    end

endmodule

// File: rtl/spec_load_guard.sv
// Module: speculative load order guard (top).
// Keeps speculatively executed loads in a circular queue in program order.
// Resolving stores and remote invalidations are checked against every slot,
// and a registered squash names the oldest offender. Assumes DEPTH is a
// power of two, ADDR_W < 32, and flushes always remove the youngest loads.
module spec_load_guard #(
    parameter int DEPTH   = 8,
    parameter int SEQ_W   = 6,
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 3,
    parameter int LINE_SH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_tag,
    input  logic              alloc_mmio,
    output logic              alloc_ready,
    input  logic              exec_valid,
    input  logic [SEQ_W-1:0]  exec_tag,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [LEN_W-1:0]  exec_len,
    input  logic              st_valid,
    input  logic [SEQ_W-1:0]  st_tag,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [LEN_W-1:0]  st_len,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              ret_valid,
    input  logic              flush_valid,
    input  logic [SEQ_W-1:0]  flush_tag,
    output logic              squash_valid,
    output logic [SEQ_W-1:0]  squash_tag
);
    import slg_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] nkill;

    logic                        alloc_go, ret_go;
    logic [DEPTH-1:0]            e_valid, st_hit, inv_hit, kill, hit;
    logic [DEPTH-1:0]            alloc_en, free_en;
    logic [DEPTH-1:0][SEQ_W-1:0] e_tag;
    logic                        pick_found;
    logic [SEQ_W-1:0]            pick_tag;

    // Accept allocations only with room and outside flush cycles (R2, R10).
    always_comb begin
        alloc_ready = (count_q != CNT_W'(DEPTH));
        alloc_go    = alloc_valid && alloc_ready && !flush_valid;
        ret_go      = ret_valid && (count_q != '0) && !flush_valid;
    end

    // Per-slot allocate, free and flush-kill strobes.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            kill[i]     = flush_valid && e_valid[i] &&
                          seq_older(32'(flush_tag), 32'(e_tag[i]), SEQ_W);
            alloc_en[i] = alloc_go && (tail_q == IDX_W'(i));
            free_en[i]  = kill[i] || (ret_go && (head_q == IDX_W'(i)));
        end
    end

    // Count the slots a flush removes.
    always_comb begin
        nkill = '0;
        for (int i = 0; i < DEPTH; i++) nkill = nkill + CNT_W'(kill[i]);
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            slg_entry #(
                .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_SH(LINE_SH)
            ) u_slot (
                .clk(clk), .rst_n(rst_n),
                .alloc_en(alloc_en[g]), .alloc_tag(alloc_tag), .alloc_mmio(alloc_mmio),
                .free_en(free_en[g]),
                .exec_valid(exec_valid), .exec_tag(exec_tag),
                .exec_addr(exec_addr), .exec_len(exec_len),
                .st_valid(st_valid), .st_tag(st_tag), .st_addr(st_addr), .st_len(st_len),
                .inv_valid(inv_valid), .inv_addr(inv_addr),
                .e_valid(e_valid[g]), .e_tag(e_tag[g]),
                .st_hit(st_hit[g]), .inv_hit(inv_hit[g])
            );
        end
    endgenerate

    // Hits on slots removed by this cycle's flush are dropped (R10).
    assign hit = (st_hit | inv_hit) & ~kill;

    slg_oldest_pick #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_pick (
        .hit(hit), .tags(e_tag), .head(head_q),
        .found(pick_found), .oldest_tag(pick_tag)
    );

    // Queue pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (flush_valid) begin
            tail_q  <= tail_q - IDX_W'(nkill);
            count_q <= count_q - nkill;
        end else begin
            if (alloc_go) tail_q <= tail_q + IDX_W'(1);
            if (ret_go)   head_q <= head_q + IDX_W'(1);
            count_q <= count_q + CNT_W'(alloc_go) - CNT_W'(ret_go);
        end
    end

    // Registered squash request (R11).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            squash_valid <= 1'b0;
            squash_tag   <= '0;
        end else begin
            squash_valid <= pick_found;
            squash_tag   <= pick_tag;
        end
    end

endmodule

// File: rtl/slg_checker.sv
// Module: temporal checks on the load order guard, bound to the top.
// Observes ports plus the occupancy counter.
module slg_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic             ret_valid,
    input logic             flush_valid,
    input logic             st_valid,
    input logic             inv_valid,
    input logic             squash_valid,
    input logic [CNT_W-1:0] count_q
);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && !ret_valid && !flush_valid) |=> !alloc_ready);

    assert_retire_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !flush_valid && !alloc_valid && count_q != '0)
        |=> (count_q == $past(count_q) - CNT_W'(1)));

    assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !st_valid && !inv_valid) |=> !squash_valid);

    assert_empty_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0) |=> !squash_valid);

    assert_squash_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> $past(st_valid || inv_valid));

endmodule

bind spec_load_guard slg_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .ret_valid(ret_valid), .flush_valid(flush_valid), .st_valid(st_valid),
    .inv_valid(inv_valid), .squash_valid(squash_valid), .count_q(count_q)
);

// File: tb/spec_load_guard_tb.sv
module spec_load_guard_tb;
    localparam int DEPTH = 4, SEQ_W = 4, ADDR_W = 16, LEN_W = 3, LINE_SH = 4;

    localparam logic [2:0] OP_AL = 3'd0, OP_EX = 3'd1, OP_ST = 3'd2,
                           OP_IV = 3'd3, OP_RT = 3'd4, OP_FL = 3'd5;
    // {op, tag, addr, len, mmio, exp_squash, exp_tag, exp_ready}
    localparam int NV = 40;
    localparam logic [32:0] VEC [NV] = '{
        {OP_AL, 4'd1, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_AL, 4'd2, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_AL, 4'd3, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_EX, 4'd2, 16'h0100, 3'd3, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_EX, 4'd3, 16'h0110, 3'd7, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_ST, 4'd0, 16'h0104, 3'd3, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_ST, 4'd0, 16'h0103, 3'd0, 1'b0, 1'b1, 4'd2, 1'b1},
        {OP_ST, 4'd2, 16'h0100, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_ST, 4'd4, 16'h0100, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_ST, 4'd1, 16'h0110, 3'd0, 1'b0, 1'b1, 4'd3, 1'b1},
        {OP_IV, 4'd0, 16'h0105, 3'd0, 1'b0, 1'b1, 4'd2, 1'b1},
        {OP_IV, 4'd0, 16'h011A, 3'd0, 1'b0, 1'b1, 4'd3, 1'b1},
        {OP_IV, 4'd0, 16'h0200, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_EX, 4'd1, 16'h011C, 3'd3, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_IV, 4'd0, 16'h0110, 3'd0, 1'b0, 1'b1, 4'd1, 1'b1},
        {OP_ST, 4'd0, 16'h0116, 3'd7, 1'b0, 1'b1, 4'd1, 1'b1},
        {OP_AL, 4'd4, 16'h0000, 3'd0, 1'b1, 1'b0, 4'd0, 1'b0},
        {OP_AL, 4'd5, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b0},
        {OP_EX, 4'd4, 16'h0300, 3'd0, 1'b0, 1'b0, 4'd0, 1'b0},
        {OP_ST, 4'd0, 16'h0300, 3'd0, 1'b0, 1'b0, 4'd0, 1'b0},
        {OP_RT, 4'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_IV, 4'd0, 16'h011C, 3'd0, 1'b0, 1'b1, 4'd3, 1'b1},
        {OP_FL, 4'd2, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_ST, 4'd0, 16'h0110, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_ST, 4'd0, 16'h0101, 3'd0, 1'b0, 1'b1, 4'd2, 1'b1},
        {OP_RT, 4'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_ST, 4'd0, 16'h0101, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_AL, 4'd7, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_AL, 4'd8, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_AL, 4'd9, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_EX, 4'd8, 16'h0400, 3'd1, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_EX, 4'd9, 16'h0400, 3'd1, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_EX, 4'd7, 16'h0400, 3'd1, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_ST, 4'd6, 16'h0401, 3'd0, 1'b0, 1'b1, 4'd7, 1'b1},
        {OP_ST, 4'd7, 16'h0400, 3'd0, 1'b0, 1'b1, 4'd8, 1'b1},
        {OP_ST, 4'd8, 16'h0400, 3'd0, 1'b0, 1'b1, 4'd9, 1'b1},
        {OP_ST, 4'd9, 16'h0400, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_FL, 4'd7, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1},
        {OP_ST, 4'd6, 16'h0400, 3'd0, 1'b0, 1'b1, 4'd7, 1'b1},
        {OP_RT, 4'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 4'd0, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              alloc_valid, alloc_mmio, alloc_ready;
    logic [SEQ_W-1:0]  alloc_tag;
    logic              exec_valid;
    logic [SEQ_W-1:0]  exec_tag;
    logic [ADDR_W-1:0] exec_addr;
    logic [LEN_W-1:0]  exec_len;
    logic              st_valid;
    logic [SEQ_W-1:0]  st_tag;
    logic [ADDR_W-1:0] st_addr;
    logic [LEN_W-1:0]  st_len;
    logic              inv_valid;
    logic [ADDR_W-1:0] inv_addr;
    logic              ret_valid, flush_valid;
    logic [SEQ_W-1:0]  flush_tag;
    logic              squash_valid;
    logic [SEQ_W-1:0]  squash_tag;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    spec_load_guard #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_SH(LINE_SH)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_mmio(alloc_mmio),
        .alloc_ready(alloc_ready),
        .exec_valid(exec_valid), .exec_tag(exec_tag), .exec_addr(exec_addr), .exec_len(exec_len),
        .st_valid(st_valid), .st_tag(st_tag), .st_addr(st_addr), .st_len(st_len),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .ret_valid(ret_valid), .flush_valid(flush_valid), .flush_tag(flush_tag),
        .squash_valid(squash_valid), .squash_tag(squash_tag)
    );

    task automatic idle_inputs();
        alloc_valid = 1'b0; alloc_mmio = 1'b0; alloc_tag = '0;
        exec_valid = 1'b0; exec_tag = '0; exec_addr = '0; exec_len = '0;
        st_valid = 1'b0; st_tag = '0; st_addr = '0; st_len = '0;
        inv_valid = 1'b0; inv_addr = '0;
        ret_valid = 1'b0; flush_valid = 1'b0; flush_tag = '0;
    endtask

    // One clock: inputs held over the rising edge, results sampled at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_squash(input string req, input logic ev, input logic [SEQ_W-1:0] et);
        check(req, "squash_valid", int'(squash_valid), int'(ev));
        if (ev) check(req, "squash_tag", int'(squash_tag), int'(et));
    endtask

    task automatic do_alloc(input int t);
        alloc_valid = 1'b1; alloc_tag = SEQ_W'(t); tick();
    endtask

    task automatic do_exec(input int t, input int a);
        exec_valid = 1'b1; exec_tag = SEQ_W'(t); exec_addr = ADDR_W'(a); exec_len = '0; tick();
    endtask

    task automatic do_ret();
        ret_valid = 1'b1; tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty after reset
        check("R1", "alloc_ready", int'(alloc_ready), 1);
        check("R1", "squash_valid", int'(squash_valid), 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [2:0]        op;
            logic [3:0]        tg;
            logic [15:0]       ad;
            logic [2:0]        ln;
            logic              mm, ev, er;
            logic [3:0]        et;
            string             req;
            {op, tg, ad, ln, mm, ev, et, er} = VEC[v];
            case (op)
                OP_AL: begin alloc_valid = 1'b1; alloc_tag = tg; alloc_mmio = mm; req = "R2/R8"; end
                OP_EX: begin exec_valid = 1'b1; exec_tag = tg; exec_addr = ad; exec_len = ln; req = "R3/R8"; end
                OP_ST: begin st_valid = 1'b1; st_tag = tg; st_addr = ad; st_len = ln; req = "R4/R5/R7"; end
                OP_IV: begin inv_valid = 1'b1; inv_addr = ad; req = "R6/R7"; end
                OP_RT: begin ret_valid = 1'b1; req = "R9"; end
                default: begin flush_valid = 1'b1; flush_tag = tg; req = "R10"; end
            endcase
            tick();
            check_squash(req, ev, et);
            check(req, "alloc_ready", int'(alloc_ready), int'(er));
        end

        // R10: flush in the same cycle as a store that hits a removed load
        do_alloc(1);
        do_exec(1, 16'h0500);
        flush_valid = 1'b1; flush_tag = 4'd0;
        st_valid = 1'b1; st_tag = 4'd0; st_addr = 16'h0500; st_len = '0;
        tick();
        check_squash("R10", 1'b0, 4'd0);
        check("R10", "alloc_ready", int'(alloc_ready), 1);

        // R10: allocation during a flush is ignored; R2: full at four
        do_alloc(2); do_alloc(3); do_alloc(4); do_alloc(5);
        check("R2", "alloc_ready full", int'(alloc_ready), 0);
        flush_valid = 1'b1; flush_tag = 4'd3; alloc_valid = 1'b1; alloc_tag = 4'd6;
        tick();
        do_alloc(6);
        check("R10", "alloc_ready after flush", int'(alloc_ready), 1);
        do_alloc(7);
        check("R10", "alloc_ready refill", int'(alloc_ready), 0);

        // R9: retire drains; retire on empty ignored
        do_ret(); do_ret(); do_ret(); do_ret();
        do_ret();
        do_alloc(8); do_alloc(9); do_alloc(10);
        check("R9", "alloc_ready three held", int'(alloc_ready), 1);
        do_alloc(11);
        check("R9", "alloc_ready four held", int'(alloc_ready), 0);

        // R11: squash lasts exactly one cycle
        do_exec(9, 16'h0600);
        st_valid = 1'b1; st_tag = 4'd8; st_addr = 16'h0600; st_len = '0;
        tick();
        check_squash("R11", 1'b1, 4'd9);
        tick();
        check_squash("R11", 1'b0, 4'd0);

        // R7: store and invalidation in one cycle, oldest offender wins
        do_exec(10, 16'h0700);
        st_valid = 1'b1; st_tag = 4'd8; st_addr = 16'h0700; st_len = '0;
        inv_valid = 1'b1; inv_addr = 16'h0600;
        tick();
        check_squash("R7", 1'b1, 4'd9);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule